// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns a single idle-high serial line into characters. A sampling enable, produced elsewhere at 16 or 8 pulses per bit time, paces the receiver. The line first passes through a two-flop synchronizer. While idle, the receiver counts consecutive low samples. It accepts a start bit only when the line has stayed low for half a bit time. From then on it takes one sample per bit period for each data bit, for the optional parity bit and for a single stop bit.

The character length, bit order and parity mode come from run-time configuration inputs. These must be held steady while a character is in flight. A finished character is placed in a holding register and announced by a one-cycle valid pulse. Parity, framing and overrun problems set sticky flags, which stay set until a clear strobe.

Top module: `ovs_serial_rx`

## Requirements
- R1: After reset, and after a reset applied in the middle of a character, `rx_valid`, `rx_data` and all three error flags are 0. The receiver then accepts the next complete character.
- R2: With `cfg_div8`=0 a start is accepted on the 8th consecutive low sample. With `cfg_div8`=1 it is accepted on the 4th. A shorter low run is rejected, and the run count restarts from zero after any high sample.
- R3: After start acceptance, a bit is sampled on every 16th sample pulse (`cfg_div8`=0) or every 8th (`cfg_div8`=1). Clock cycles without `samp_en` do not advance any count.
- R4: `cfg_len` codes 0..3 select 5..8 data bits, and codes 4..7 select 9 bits. Bits of `rx_data` above the character length read 0.
- R5: With `cfg_msb_first`=0 the first data bit received lands in `rx_data[0]`. With `cfg_msb_first`=1 it lands in `rx_data[len-1]`.
- R6: `cfg_par` selects the parity bit: 0 even, 1 odd, 2 always 0, 3 always 1, 4..7 no parity bit. A parity bit that does not match sets `err_parity`, which stays set until cleared.
- R7: Exactly one stop bit is checked. A low stop sample sets `err_frame`, and the character is still delivered.
- R8: The start search resumes right after the stop sample, so characters sent back to back with one stop bit are all received.
- R9: `rx_valid` is high for exactly one clock, one clock after the stop sample, and `rx_data` holds the new character in that cycle.
- R10: If a character completes while the previous one has not been acknowledged with `rx_ack`, `err_overrun` is set and `rx_data` is overwritten with the new character.
- R11: `err_clr` clears all three flags. A flag that is being set in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_en | input | 1 | Sampling enable, 16 or 8 pulses per bit |
| rx_line | input | 1 | Serial input, idle high |
| cfg_div8 | input | 1 | 0: 16 samples per bit, 1: 8 samples per bit |
| cfg_len | input | 3 | Character length code |
| cfg_msb_first | input | 1 | Bit order select |
| cfg_par | input | 3 | Parity mode code |
| rx_ack | input | 1 | Acknowledges the held character |
| err_clr | input | 1 | Clears the error flags |
| rx_data | output | 9 | Held character |
| rx_valid | output | 1 | One-cycle completion pulse |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun |

## Verification
The bound checker keeps its own count of low samples and of sample pulses. On every cycle it checks the following:
- a start is accepted only at the half-bit run length;
- every bit sample falls one full bit period after the previous event;
- the receiver is idle right after the stop sample;
- the valid pulse lasts one cycle and follows the stop sample;
- a low stop bit raises the framing flag;
- the parity flag holds until cleared.

Only the bench scenarios can show the following: that the assembled data is correct for each length, order and parity combination; that short low pulses are rejected; that back-to-back characters are received; that overrun overwrites the held character; and that a reset in the middle of a character recovers cleanly.

// File: rtl/ovs_rx_pkg.sv
package ovs_rx_pkg;

  localparam int MAX_CHR = 9;

  typedef enum logic [2:0] {
    PAR_EVEN = 3'd0,
    PAR_ODD  = 3'd1,
    PAR_ZERO = 3'd2,
    PAR_ONE  = 3'd3,
    PAR_NONE = 3'd4
  } par_mode_e;

  // number of data bits for a length code; codes 4..7 all give nine
  function automatic logic [3:0] chr_bits(input logic [2:0] code);
    return (code >= 3'd4) ? 4'd9 : (4'(code) + 4'd5);
  endfunction

  function automatic logic par_used(input logic [2:0] mode);
    return mode < 3'd4;
  endfunction

  // value the parity bit must carry for the assembled data
  function automatic logic par_expect(input logic [MAX_CHR-1:0] d, input logic [2:0] mode);
    logic r;
    case (par_mode_e'(mode))
      PAR_EVEN: r = ^d;
      PAR_ODD:  r = ~^d;
      PAR_ZERO: r = 1'b0;
      PAR_ONE:  r = 1'b1;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

  // position in the holding register of the idx-th received data bit
  function automatic logic [3:0] bit_slot(input logic [3:0] idx, input logic [3:0] nbits,
                                          input logic msb);
    return msb ? (nbits - 4'd1 - idx) : idx;
  endfunction

  // bit slots after the start bit: data, optional parity, one stop
  function automatic logic [3:0] frame_slots(input logic [3:0] nbits, input logic [2:0] mode);
    return nbits + {3'b000, par_used(mode)} + 4'd1;
  endfunction

endpackage

// File: rtl/ovs_rx_sync.sv
module ovs_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d_in};
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/ovs_rx_bitclk.sv
module ovs_rx_bitclk #(
  parameter int OS_FAST = 16,
  parameter int OS_SLOW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       samp_en,
  input  logic       rx_bit,
  input  logic       div8,
  input  logic [3:0] slots,
  output logic       start_hit,
  output logic       bit_tick,
  output logic       last_tick,
  output logic       busy,
  output logic [3:0] slot_idx
);
  localparam int CW = $clog2(OS_FAST);

  logic [CW-1:0] low_run_q;
  logic [CW-1:0] phase_q;
  logic [CW-1:0] half_last;
  logic [CW-1:0] period_last;

  assign half_last   = div8 ? CW'(OS_SLOW/2 - 1) : CW'(OS_FAST/2 - 1);
  assign period_last = div8 ? CW'(OS_SLOW - 1)   : CW'(OS_FAST - 1);

  assign start_hit = samp_en && !busy && !rx_bit && (low_run_q == half_last);
  assign bit_tick  = samp_en && busy && (phase_q == period_last);
  assign last_tick = bit_tick && (slot_idx == slots - 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      low_run_q <= '0;
      phase_q   <= '0;
      slot_idx  <= '0;
    end else if (samp_en) begin
      if (!busy) begin
        if (rx_bit) begin
          low_run_q <= '0;
        end else if (start_hit) begin
          busy      <= 1'b1;
          low_run_q <= '0;
          phase_q   <= '0;
          slot_idx  <= '0;
        end else begin
          low_run_q <= low_run_q + 1'b1;
        end
      end else if (bit_tick) begin
        phase_q <= '0;
        if (last_tick) busy     <= 1'b0;
        else           slot_idx <= slot_idx + 4'd1;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ovs_rx_assemble.sv
module ovs_rx_assemble
  import ovs_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_hit,
  input  logic               bit_tick,
  input  logic               rx_bit,
  input  logic [3:0]         slot_idx,
  input  logic [3:0]         nbits,
  input  logic               msb_first,
  input  logic [2:0]         par_mode,
  output logic [MAX_CHR-1:0] data_q,
  output logic               par_bad
);
  logic [3:0] dest;
  logic       is_data;
  logic       is_par;

  assign dest    = bit_slot(slot_idx, nbits, msb_first);
  assign is_data = slot_idx < nbits;
  assign is_par  = (slot_idx == nbits) && par_used(par_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      par_bad <= 1'b0;
    end else if (start_hit) begin
      data_q  <= '0;
      par_bad <= 1'b0;
    end else if (bit_tick) begin
      if (is_data) begin
        for (int k = 0; k < MAX_CHR; k++)
          if (4'(k) == dest) data_q[k] <= rx_bit;
      end else if (is_par) begin
        par_bad <= (rx_bit != par_expect(data_q, par_mode));
      end
    end
  end
endmodule

// File: rtl/ovs_serial_rx.sv
module ovs_serial_rx
  import ovs_rx_pkg::*;
#(
  parameter int OS_FAST     = 16,
  parameter int OS_SLOW     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               samp_en,
  input  logic               rx_line,
  input  logic               cfg_div8,
  input  logic [2:0]         cfg_len,
  input  logic               cfg_msb_first,
  input  logic [2:0]         cfg_par,
  input  logic               rx_ack,
  input  logic               err_clr,
  output logic [MAX_CHR-1:0] rx_data,
  output logic               rx_valid,
  output logic               err_parity,
  output logic               err_frame,
  output logic               err_overrun
);
  // named internal events, also observed by the bound checker
  logic               rx_s;
  logic               start_hit;
  logic               bit_tick;
  logic               last_tick;
  logic               busy;
  logic [3:0]         slot_idx;
  logic [3:0]         nbits;
  logic [3:0]         slots;
  logic [MAX_CHR-1:0] asm_data;
  logic               par_bad;
  logic               pending;

  assign nbits = chr_bits(cfg_len);
  assign slots = frame_slots(nbits, cfg_par);

  ovs_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (rx_line),
    .d_out (rx_s)
  );

  ovs_rx_bitclk #(.OS_FAST(OS_FAST), .OS_SLOW(OS_SLOW)) u_bitclk (
    .clk       (clk),
    .rst_n     (rst_n),
    .samp_en   (samp_en),
    .rx_bit    (rx_s),
    .div8      (cfg_div8),
    .slots     (slots),
    .start_hit (start_hit),
    .bit_tick  (bit_tick),
    .last_tick (last_tick),
    .busy      (busy),
    .slot_idx  (slot_idx)
  );

  ovs_rx_assemble u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_hit (start_hit),
    .bit_tick  (bit_tick),
    .rx_bit    (rx_s),
    .slot_idx  (slot_idx),
    .nbits     (nbits),
    .msb_first (cfg_msb_first),
    .par_mode  (cfg_par),
    .data_q    (asm_data),
    .par_bad   (par_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_valid    <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
      pending     <= 1'b0;
    end else begin
      rx_valid    <= last_tick;
      if (last_tick) rx_data <= asm_data;
      err_parity  <= (err_parity  & ~err_clr) | (last_tick & par_bad);
      err_frame   <= (err_frame   & ~err_clr) | (last_tick & ~rx_s);
      err_overrun <= (err_overrun & ~err_clr) | (last_tick & pending & ~rx_ack);
      pending     <= last_tick | (pending & ~rx_ack);
    end
  end
endmodule

// File: rtl/ovs_serial_rx_chk.sv
module ovs_serial_rx_chk #(
  parameter int OS_FAST = 16,
  parameter int OS_SLOW = 8
) (
  input logic clk,
  input logic rst_n,
  input logic samp_en,
  input logic rx_s,
  input logic div8,
  input logic start_hit,
  input logic bit_tick,
  input logic last_tick,
  input logic busy,
  input logic rx_valid,
  input logic err_parity,
  input logic err_frame,
  input logic err_clr
);
  localparam int CW = $clog2(OS_FAST) + 1;

  logic [CW-1:0] low_seen;
  logic [CW-1:0] since_evt;
  logic [CW-1:0] need_half;
  logic [CW-1:0] need_period;

  assign need_half   = div8 ? CW'(OS_SLOW/2 - 1) : CW'(OS_FAST/2 - 1);
  assign need_period = div8 ? CW'(OS_SLOW - 1)   : CW'(OS_FAST - 1);

  // independent count of low samples seen while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_seen <= '0;
    else if (samp_en) begin
      if (busy || rx_s)      low_seen <= '0;
      else if (~&low_seen)   low_seen <= low_seen + 1'b1;
    end
  end

  // sample pulses since the last start or bit sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_evt <= '0;
    else if (start_hit || bit_tick) since_evt <= '0;
    else if (samp_en && busy && ~&since_evt) since_evt <= since_evt + 1'b1;
  end

  p_start_halfbit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_hit |-> (low_seen == need_half));

  p_bit_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (since_evt == need_period));

  p_frame_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_tick && !rx_s) |=> err_frame);

  p_hunt_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_tick |=> !busy);

  p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    last_tick |=> rx_valid);

  p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_parity_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_parity && !err_clr) |=> err_parity);
endmodule

bind ovs_serial_rx ovs_serial_rx_chk #(.OS_FAST(OS_FAST), .OS_SLOW(OS_SLOW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .samp_en    (samp_en),
  .rx_s       (rx_s),
  .div8       (cfg_div8),
  .start_hit  (start_hit),
  .bit_tick   (bit_tick),
  .last_tick  (last_tick),
  .busy       (busy),
  .rx_valid   (rx_valid),
  .err_parity (err_parity),
  .err_frame  (err_frame),
  .err_clr    (err_clr)
);

// File: tb/ovs_serial_rx_tb_top.sv
module ovs_serial_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       samp_en = 1'b0;
  logic       rx_line = 1'b1;
  logic       cfg_div8 = 1'b0;
  logic [2:0] cfg_len = 3'd3;
  logic       cfg_msb_first = 1'b0;
  logic [2:0] cfg_par = 3'd4;
  logic       rx_ack = 1'b0;
  logic       err_clr = 1'b0;
  logic [8:0] rx_data;
  logic       rx_valid;
  logic       err_parity;
  logic       err_frame;
  logic       err_overrun;

  always #10 clk = ~clk;

  ovs_serial_rx dut_i (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rx_line(rx_line),
    .cfg_div8(cfg_div8), .cfg_len(cfg_len), .cfg_msb_first(cfg_msb_first),
    .cfg_par(cfg_par), .rx_ack(rx_ack), .err_clr(err_clr),
    .rx_data(rx_data), .rx_valid(rx_valid), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun)
  );

  int   n_chk = 0;
  int   n_bad = 0;
  int   gap = 0;
  bit   finished = 0;

  // capture of completed characters
  int         cap_n = 0;
  int         long_pulse = 0;
  logic [8:0] cap_data = '0;
  logic [8:0] cap_prev = '0;
  logic       cap_pe = 0;
  logic       cap_fe = 0;
  logic       v_d = 0;

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      cap_n    = cap_n + 1;
      cap_prev = cap_data;
      cap_data = rx_data;
      cap_pe   = err_parity;
      cap_fe   = err_frame;
      if (v_d) long_pulse = long_pulse + 1;
    end
    v_d = rx_valid;
  end

  // {div8, len code, msb first, parity code, data, corrupt parity, low stop}
  localparam logic [18:0] VEC [9] = '{
    {1'b0, 3'd3, 1'b0, 3'd4, 9'h0A5, 1'b0, 1'b0},
    {1'b0, 3'd3, 1'b1, 3'd0, 9'h03C, 1'b0, 1'b0},
    {1'b1, 3'd2, 1'b0, 3'd1, 9'h055, 1'b0, 1'b0},
    {1'b1, 3'd0, 1'b1, 3'd3, 9'h013, 1'b0, 1'b0},
    {1'b0, 3'd4, 1'b0, 3'd2, 9'h1C3, 1'b0, 1'b0},
    {1'b0, 3'd1, 1'b0, 3'd0, 9'h02D, 1'b1, 1'b0},
    {1'b1, 3'd3, 1'b1, 3'd1, 9'h081, 1'b0, 1'b1},
    {1'b0, 3'd7, 1'b1, 3'd5, 9'h155, 1'b0, 1'b0},
    {1'b1, 3'd4, 1'b1, 3'd0, 9'h0F0, 1'b1, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic one(input logic v);
    @(negedge clk); samp_en = 1'b1; rx_line = v;
    @(negedge clk); samp_en = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic hold(input logic v, input int n);
    for (int i = 0; i < n; i++) one(v);
  endtask

  function automatic int len_of(input logic [2:0] code);
    return (code > 3'd3) ? 9 : int'(code) + 5;
  endfunction

  function automatic logic tb_par(input logic [8:0] d, input int nb, input logic [2:0] mode);
    int ones = 0;
    for (int i = 0; i < nb; i++) if (d[i]) ones++;
    if (mode == 3'd0) return (ones % 2) == 1;
    if (mode == 3'd1) return (ones % 2) == 0;
    if (mode == 3'd3) return 1'b1;
    return 1'b0;
  endfunction

  task automatic send(input logic div8, input logic [2:0] len, input logic msb,
                      input logic [2:0] par, input logic [8:0] data, input logic badp,
                      input logic bads, input int idle);
    int os = div8 ? 8 : 16;
    int nb = len_of(len);
    cfg_div8 = div8; cfg_len = len; cfg_msb_first = msb; cfg_par = par;
    hold(1'b0, os);
    for (int i = 0; i < nb; i++) hold(msb ? data[nb-1-i] : data[i], os);
    if (par < 3'd4) hold(tb_par(data, nb, par) ^ badp, os);
    if (bads) begin hold(1'b0, os*3/4); hold(1'b1, os/4); end
    else hold(1'b1, os);
    hold(1'b1, idle);
  endtask

  task automatic ack_clr(input logic a, input logic c);
    @(negedge clk); rx_ack = a; err_clr = c;
    @(negedge clk); rx_ack = 1'b0; err_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk = n_chk + 1; n_bad = n_bad + 1;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [8:0] msk;
    int base;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 rx_valid at reset", rx_valid, 0);
    check("R1 rx_data at reset", rx_data, 0);
    check("R1 flags at reset", {err_parity, err_frame, err_overrun}, 0);
    rst_n = 1'b1;
    hold(1'b1, 20);

    // vector table walk
    for (int v = 0; v < 9; v++) begin
      logic [18:0] e = VEC[v];
      int nb = len_of(e[17:15]);
      msk = 9'((1 << nb) - 1);
      ack_clr(1'b1, 1'b1);
      base = cap_n;
      send(e[18], e[17:15], e[14], e[13:11], e[10:2], e[1], e[0], 6);
      check("R9 one character delivered", cap_n, base + 1);
      check("R4 R5 data for length and order", cap_data, e[10:2] & msk);
      check("R6 parity flag", cap_pe, (e[13:11] < 3'd4) && e[1]);
      check("R7 framing flag", cap_fe, e[0]);
    end
    check("R9 valid pulse width one cycle", long_pulse, 0);

    // R2 short low runs rejected, 16x
    ack_clr(1'b1, 1'b1);
    cfg_div8 = 0; cfg_len = 3'd3; cfg_msb_first = 0; cfg_par = 3'd4;
    base = cap_n;
    hold(1'b0, 7); hold(1'b1, 30);
    hold(1'b0, 7); hold(1'b1, 1); hold(1'b0, 7); hold(1'b1, 40);
    check("R2 16x seven lows rejected", cap_n, base);
    // R2 exactly eight lows accepted
    hold(1'b0, 8); hold(1'b1, 16*11);
    check("R2 16x eight lows accepted", cap_n, base + 1);
    check("R2 16x idle data all ones", cap_data, 9'h0FF);

    // R2 8x thresholds
    ack_clr(1'b1, 1'b1);
    cfg_div8 = 1; base = cap_n;
    hold(1'b0, 3); hold(1'b1, 20);
    check("R2 8x three lows rejected", cap_n, base);
    hold(1'b0, 4); hold(1'b1, 8*11);
    check("R2 8x four lows accepted", cap_n, base + 1);

    // R3 idle clocks between sample pulses do not count
    ack_clr(1'b1, 1'b1);
    gap = 5; base = cap_n;
    send(1'b0, 3'd3, 1'b0, 3'd0, 9'h096, 1'b0, 1'b0, 6);
    gap = 0;
    check("R3 gapped enable count", cap_n, base + 1);
    check("R3 gapped enable data", cap_data, 9'h096);

    // R8 back-to-back characters with one stop bit
    ack_clr(1'b1, 1'b1);
    base = cap_n;
    send(1'b1, 3'd3, 1'b0, 3'd0, 9'h05A, 1'b0, 1'b0, 0);
    send(1'b1, 3'd3, 1'b0, 3'd0, 9'h0A5, 1'b0, 1'b0, 4);
    check("R8 both characters received", cap_n, base + 2);
    check("R8 first character", cap_prev, 9'h05A);
    check("R8 second character", cap_data, 9'h0A5);

    // R10 overrun
    ack_clr(1'b1, 1'b1);
    send(1'b0, 3'd3, 1'b0, 3'd4, 9'h011, 1'b0, 1'b0, 4);
    check("R10 no overrun after first", err_overrun, 0);
    send(1'b0, 3'd3, 1'b0, 3'd4, 9'h022, 1'b0, 1'b0, 4);
    check("R10 overrun set", err_overrun, 1);
    check("R10 data overwritten", rx_data, 9'h022);

    // R11 clear
    ack_clr(1'b1, 1'b0);
    check("R11 ack alone keeps overrun", err_overrun, 1);
    ack_clr(1'b0, 1'b1);
    check("R11 clear drops overrun", err_overrun, 0);

    // R6 stickiness across a good character
    send(1'b0, 3'd3, 1'b0, 3'd0, 9'h033, 1'b1, 1'b0, 4);
    ack_clr(1'b1, 1'b0);
    send(1'b0, 3'd3, 1'b0, 3'd0, 9'h044, 1'b0, 1'b0, 4);
    check("R6 parity flag sticky", err_parity, 1);
    check("R6 later good data", rx_data, 9'h044);
    ack_clr(1'b1, 1'b1);
    check("R11 clear drops parity", err_parity, 0);

    // R1 reset in the middle of a character
    cfg_div8 = 0;
    hold(1'b0, 16); hold(1'b1, 24);
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 mid-frame reset outputs", {rx_valid, err_parity, err_frame, err_overrun}, 0);
    check("R1 mid-frame reset data", rx_data, 0);
    rst_n = 1'b1;
    hold(1'b1, 20);
    base = cap_n;
    send(1'b0, 3'd3, 1'b1, 3'd1, 9'h0C7, 1'b0, 1'b0, 6);
    check("R1 recovery character count", cap_n, base + 1);
    check("R1 recovery character data", cap_data, 9'h0C7);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule